// File: doc/BRIEF.md
# Time-Shared Carry-Select Adder

This block adds two 16-bit operands and a carry-in and returns a 16-bit sum and a carry-out. It is a carry-select adder split into five bit groups. The lowest group is a plain ripple adder that takes the real carry-in. Each of the four upper groups has a single ripple adder that is used twice in every two-cycle period.

An internal phase bit alternates between a "high" cycle and a "low" cycle. In the high cycle every upper group adds with its carry-in forced to one, and the group's sum and carry are captured in a register at the end of that cycle. In the low cycle the same adder runs with its carry-in forced to zero. In each upper group, a row of 2:1 selectors is steered by the real carry arriving from the group below. A carry of one picks the captured result and a carry of zero picks the live result.

At the end of every low cycle the selected 17-bit result is registered at the outputs, and a one-cycle valid pulse follows. The user keeps the operands steady across one high cycle and the low cycle after it. Changing them while the valid pulse is high lines the next operation up with the next pair of cycles.

Top module: `tsa_timeshare_adder`

## Requirements
- R1: On every cycle that `valid_o` is 1, {`cout_o`,`sum_o`} equals `a_i` + `b_i` + `cin_i` as a 17-bit value. The operands are the ones held over the two cycles before that cycle.
- R2: Bits 1:0 form the lowest group, a ripple adder driven by the true `cin_i`. A carry-in of one is added at bit 0 (for example 3 + 0 + 1 gives 4).
- R3: The groups span 2, 2, 3 and 4 bits from the bottom, and the most significant group spans 5 bits. The upper groups therefore start at bits 2, 4, 7 and 11. A carry that ripples up to any of these starting bits yields the exact power of two.
- R4: The phase alternates every clock cycle, and the first cycle after reset release is a high cycle. Upper groups capture their forced-carry-one result only at the end of a high cycle.
- R5: Each upper group outputs its captured forced-carry-one sum and carry when the carry from the group below is 1. It outputs its live forced-carry-zero sum and carry when that carry is 0. A captured carry is never below the live carry for the same operands.
- R6: `valid_o` is a single-cycle pulse that follows the end of each low cycle, so pulses come every two cycles. Between pulses `sum_o` and `cout_o` hold their last value.
- R7: While `rst_n` is low, `valid_o`, `sum_o` and `cout_o` are 0.
- R8: `cout_o` is the carry-out of the most significant group (for example 0x8000 + 0x8000 gives `cout_o`=1 and `sum_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each add takes one high and one low cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | 16 | Registered sum |
| cout_o | output | 1 | Registered carry-out |
| valid_o | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The result and carry-ordering properties assume that `a_i`, `b_i` and `cin_i` do not change between the end of a high cycle and the end of the low cycle after it. If they did, the captured and live halves would belong to different operands. The stimulus respects this because it applies new operands only on the falling edge inside a valid-pulse cycle, which is always a high cycle. Operands then stay untouched until the next pulse. Directed cases push carries exactly onto each group boundary and through the whole word. Seeded random operand pairs fill in the rest.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

  // Number of carry-select groups, least significant first
  localparam int unsigned NUM_GRP = 5;

  // Width of each group, index 0 is the plain ripple group
  localparam int unsigned GRP_W [NUM_GRP] = '{2, 2, 3, 4, 5};

  // Number of reset synchronizer stages
  localparam int unsigned SYNC_STAGES = 2;

  // Lowest bit position of group g (equals total width for g == NUM_GRP)
  function automatic int unsigned grp_lo(input int unsigned g);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < NUM_GRP; k++) begin
      if (k < g) acc += GRP_W[k];
    end
    return acc;
  endfunction

  localparam int unsigned DATA_W = grp_lo(NUM_GRP);

  typedef logic [DATA_W-1:0] word_t;

endpackage

// File: rtl/tsa_rca.sv
module tsa_rca #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);

  logic [W:0] c;

  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p      = a[i] ^ b[i];
    assign s[i]   = p ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (p & c[i]);
  end

  assign co = c[W];

endmodule

// File: rtl/tsa_phase_ctrl.sv
module tsa_phase_ctrl #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n,
  output logic phase_hi,
  output logic load
);

  // Reset synchronizer: asserts at once, releases on a clock edge
  logic [SYNC_N-1:0] sync_q;
  logic [SYNC_N-1:0] sync_d;

  if (SYNC_N > 1) begin : g_sync_multi
    assign sync_d = {sync_q[SYNC_N-2:0], 1'b1};
  end else begin : g_sync_single
    assign sync_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[SYNC_N-1];

  // Phase: 1 = forced-carry-one cycle, 0 = forced-carry-zero cycle
  logic phase_q;
  logic phase_d;

  always_comb begin
    phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) phase_q <= 1'b1;
    else             phase_q <= phase_d;
  end

  assign phase_hi = phase_q;
  assign load     = ~phase_q;

endmodule

// File: rtl/tsa_shared_group.sv
module tsa_shared_group #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         sel_ci,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] s,
  output logic         co,
  output logic         live_co,
  output logic         held_co
);

  logic [W-1:0] s_live;
  logic         c_live;

  // One adder; its carry-in follows the phase (1 while capturing)
  tsa_rca #(.W(W)) u_rca (
    .a  (a),
    .b  (b),
    .ci (cap_en),
    .s  (s_live),
    .co (c_live)
  );

  logic [W:0] held_q;
  logic [W:0] held_d;

  always_comb begin
    if (cap_en) held_d = {c_live, s_live};
    else        held_d = held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  // Selection row of 2:1 multiplexers
  for (genvar i = 0; i < W; i++) begin : g_mux
    assign s[i] = sel_ci ? held_q[i] : s_live[i];
  end
  assign co = sel_ci ? held_q[W] : c_live;

  assign live_co = c_live;
  assign held_co = held_q[W];

endmodule

// File: rtl/tsa_timeshare_adder.sv
module tsa_timeshare_adder
  import tsa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              valid_o
);

  logic rst_sync_n;
  logic phase_hi;
  logic load;

  tsa_phase_ctrl #(.SYNC_N(SYNC_STAGES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n),
    .phase_hi   (phase_hi),
    .load       (load)
  );

  logic [NUM_GRP:0]   carry;
  word_t              sum_c;
  logic [NUM_GRP-1:1] live_c;
  logic [NUM_GRP-1:1] held_c;

  assign carry[0] = cin_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int unsigned LO = grp_lo(g);
    localparam int unsigned GW = GRP_W[g];
    localparam int unsigned HI = LO + GW - 1;
    if (g == 0) begin : g_base
      tsa_rca #(.W(GW)) u_base (
        .a  (a_i[HI:LO]),
        .b  (b_i[HI:LO]),
        .ci (carry[0]),
        .s  (sum_c[HI:LO]),
        .co (carry[1])
      );
    end else begin : g_shared
      tsa_shared_group #(.W(GW)) u_grp (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .cap_en  (phase_hi),
        .sel_ci  (carry[g]),
        .a       (a_i[HI:LO]),
        .b       (b_i[HI:LO]),
        .s       (sum_c[HI:LO]),
        .co      (carry[g+1]),
        .live_co (live_c[g]),
        .held_co (held_c[g])
      );
    end
  end

  // Output register, loaded at the end of each low cycle
  word_t sum_q, sum_d;
  logic  cout_q, cout_d;
  logic  valid_q, valid_d;

  always_comb begin
    sum_d   = sum_q;
    cout_d  = cout_q;
    valid_d = load;
    if (load) begin
      sum_d  = sum_c;
      cout_d = carry[NUM_GRP];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sum_q   <= '0;
      cout_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      sum_q   <= sum_d;
      cout_q  <= cout_d;
      valid_q <= valid_d;
    end
  end

  assign sum_o   = sum_q;
  assign cout_o  = cout_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/tsa_adder_chk.sv
module tsa_adder_chk
  import tsa_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               rst_sync_n,
  input logic               phase_hi,
  input logic [DATA_W-1:0]  a_i,
  input logic [DATA_W-1:0]  b_i,
  input logic               cin_i,
  input logic [DATA_W-1:0]  sum_o,
  input logic               cout_o,
  input logic               valid_o,
  input logic [NUM_GRP-1:1] live_c,
  input logic [NUM_GRP-1:1] held_c
);

  // R1: registered result matches the operands of the finished pair
  p_sum_exact_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_o |-> ({cout_o, sum_o} ==
                 ({1'b0, $past(a_i)} + {1'b0, $past(b_i)} +
                  {{DATA_W{1'b0}}, $past(cin_i)})));

  // R4: phase alternates
  p_phase_fall_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phase_hi |=> !phase_hi);
  p_phase_rise_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !phase_hi |=> phase_hi);

  // R5: captured carry never below live carry for held operands
  p_carry_order_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!phase_hi && $stable(a_i) && $stable(b_i)) |->
      ((live_c & ~held_c) == '0));

  // R6: valid is a single pulse following a low cycle; outputs held otherwise
  p_valid_after_low_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_o |-> $past(!phase_hi));
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_o |=> !valid_o);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phase_hi |=> $stable({cout_o, sum_o}));

  // R7: outputs cleared while reset is asserted
  p_reset_clear_r7: assert property (@(posedge clk)
    !rst_n |-> (!valid_o && !cout_o && (sum_o == '0)));

endmodule

bind tsa_timeshare_adder tsa_adder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .phase_hi   (phase_hi),
  .a_i        (a_i),
  .b_i        (b_i),
  .cin_i      (cin_i),
  .sum_o      (sum_o),
  .cout_o     (cout_o),
  .valid_o    (valid_o),
  .live_c     (live_c),
  .held_c     (held_c)
);

// File: tb/tsa_timeshare_adder_tb.sv
module tsa_timeshare_adder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic [15:0] a_i, b_i;
  logic        cin_i;
  logic [15:0] sum_o;
  logic        cout_o;
  logic        valid_o;

  int checks;
  int errors;
  bit done;

  tsa_timeshare_adder u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .valid_o (valid_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [16:0] ref_add(input logic [15:0] a, input logic [15:0] b,
                                          input logic c);
    return {1'b0, a} + {1'b0, b} + {16'd0, c};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [16:0] got,
                     input logic [16:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  logic [16:0] prev_res;

  // Apply operands inside a valid (high) cycle, then check hold and result
  task automatic run_op(input logic [15:0] a, input logic [15:0] b, input logic c,
                        input string tag);
    logic [16:0] exp;
    exp   = ref_add(a, b, c);
    a_i   = a;
    b_i   = b;
    cin_i = c;
    @(negedge clk);
    chk(!valid_o, "R6 valid low between pulses", {16'd0, valid_o}, 17'd0);
    chk({cout_o, sum_o} == prev_res, "R6 output held", {cout_o, sum_o}, prev_res);
    @(negedge clk);
    chk(valid_o, "R6 valid pulse every two cycles", {16'd0, valid_o}, 17'd1);
    chk({cout_o, sum_o} == exp, tag, {cout_o, sum_o}, exp);
    prev_res = {cout_o, sum_o};
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed;
    int          waited;
    checks = 0;
    errors = 0;
    done   = 1'b0;
    seed   = $urandom(32'd2718);
    rst_n  = 1'b0;
    a_i    = 16'd0;
    b_i    = 16'd0;
    cin_i  = 1'b0;
    repeat (4) @(negedge clk);
    // R7 reset state
    chk(!valid_o, "R7 valid in reset", {16'd0, valid_o}, 17'd0);
    chk({cout_o, sum_o} == 17'd0, "R7 result in reset", {cout_o, sum_o}, 17'd0);
    rst_n = 1'b1;

    waited = 0;
    @(negedge clk);
    while (!valid_o && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    chk(valid_o, "R4 first pulse after reset", {16'd0, valid_o}, 17'd1);
    chk({cout_o, sum_o} == 17'd0, "R1 first result", {cout_o, sum_o}, 17'd0);
    prev_res = {cout_o, sum_o};

    // R2 lowest group with true carry-in
    run_op(16'h0000, 16'h0000, 1'b1, "R2 carry-in alone");
    run_op(16'h0003, 16'h0000, 1'b1, "R2 carry-in through base group");
    run_op(16'h0001, 16'h0002, 1'b0, "R2 small sum");

    // R3 carry landing exactly on each group start bit (2, 4, 7, 11)
    run_op(16'h0003, 16'h0001, 1'b0, "R3 boundary bit 2");
    run_op(16'h000F, 16'h0001, 1'b0, "R3 boundary bit 4");
    run_op(16'h007F, 16'h0001, 1'b0, "R3 boundary bit 7");
    run_op(16'h07FF, 16'h0001, 1'b0, "R3 boundary bit 11");
    run_op(16'h07FF, 16'h0000, 1'b1, "R3 boundary bit 11 via carry-in");

    // R5 stored versus live selection
    run_op(16'hFFFF, 16'h0000, 1'b1, "R5 all groups pick stored result");
    run_op(16'h5555, 16'hAAAA, 1'b0, "R5 all groups pick live result");
    run_op(16'h5555, 16'hAAAA, 1'b1, "R5 full propagate chain");
    run_op(16'h0C30, 16'h03D0, 1'b0, "R5 mixed selections");

    // R8 carry-out from top group
    run_op(16'h8000, 16'h8000, 1'b0, "R8 top carry, zero sum");
    run_op(16'hFFFF, 16'hFFFF, 1'b1, "R8 maximum operands");
    run_op(16'h7FFF, 16'h0001, 1'b0, "R8 no carry-out at top bit");

    // R1 seeded random pairs
    for (int i = 0; i < 300; i++) begin
      logic [15:0] ra, rb;
      logic        rc;
      ra = 16'($urandom());
      rb = 16'($urandom());
      rc = 1'($urandom());
      run_op(ra, rb, rc, "R1 random sum");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule